// File: doc/BRIEF.md
# Link Self-Test Payload Error Checker

This block sits at the receive end of a high-speed serial link while the link runs an at-speed self test. During the test the far end sends a payload that, once descrambled and decoded, should contain only zero bits. The checker starts when a test-enable level goes high and waits for the receiver PLL to report lock. After lock it inspects every valid 35-bit payload word. A word with any bit set counts as an errored payload.

A single result pin, `passOut`, has two jobs. While the test runs it sits high and drops low for exactly one fast-clock cycle for each errored payload. The fast clock runs at twice the pixel rate, so that strobe lasts half a pixel period, and outside logic can count the strobes. When the enable falls, the pin settles to a sticky verdict: high if no errored payload was seen, low otherwise. The verdict stays until the next test starts or reset is applied.

The checker also keeps a saturating count of lock losses during the test and a registered copy of the lock indication, which software can read.

Top module: `bist_link_checker`

## Requirements
- R1: A rising edge of `bistEn` starts a new test. One cycle later `passOut` is 0 and `errCnt` is 0. `passOut` stays 0 while the checker waits for lock.
- R2: The first cycle that has `pllLock` high while the checker waits with `bistEn` high sets `passOut` to 1 one cycle later. The payload presented in that cycle is not checked.
- R3: While checking, a cycle with `payloadValid` high and any of the 35 payload bits at 1 drives `passOut` to 0 for exactly the next cycle. `passOut` then returns to 1 unless the following payload is also errored.
- R4: A payload with `payloadValid` low, or a valid all-zero payload, never causes a low strobe.
- R5: If `pllLock` falls while checking, `errCnt` increases by 1 one cycle later and `passOut` stays 1. Payloads are then ignored until lock returns, and the return of lock resumes checking as in R2.
- R6: `errCnt` is 8 bits wide and saturates at 255.
- R7: When `bistEn` falls during a test, `passOut` becomes 1 one cycle later if no errored payload was seen since the test started, and 0 otherwise. A payload presented in the cycle where enable is already low is ignored. A test that ends before lock is ever reached reports 1.
- R8: After the test ends, `passOut` and `errCnt` hold their values. Changes on `pllLock`, `payloadValid` and `payload` do not affect them. They change only on a new rising edge of `bistEn` or on reset.
- R9: `lockStatus` equals `pllLock` delayed by one clock cycle.
- R10: While `rst_n` is low, `passOut`, `errCnt` and `lockStatus` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock at twice the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| bistEn | input | 1 | Self-test enable level |
| pllLock | input | 1 | Receiver PLL lock indication |
| payloadValid | input | 1 | Qualifies `payload` as a decoded payload word |
| payload | input | 35 | Decoded payload word, expected all zero |
| passOut | output | 1 | Live error strobe during a test; sticky verdict after it |
| errCnt | output | 8 | Saturating count of lock losses during the test |
| lockStatus | output | 1 | Registered lock indication |

## Verification
Three pairs of events can land in the same cycle. An errored payload can arrive in the same cycle that lock drops, or in the same cycle that enable falls. A strobe can also be followed directly by the end of the test. The bench drives an all-ones valid payload together with the lock drop, and with the enable fall. It expects no strobe and an unchanged verdict in both cases. It then places an errored payload in the cycle just before enable falls and expects the verdict to be low. The saturation run alternates lock and loss well past 255 losses and checks that the counter stops at its ceiling.

// File: rtl/bist_chk_pkg.sv
package bist_chk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_CHECK = 2'd2,
    ST_HOLD  = 2'd3
  } bistState_e;

  // One-cycle strobes from control to datapath
  typedef struct packed {
    logic clearRes;  // new test begins
    logic startChk;  // lock reached, begin comparing
    logic checkAct;  // this cycle's payload is compared
    logic lockDrop;  // lock lost while comparing
    logic endTest;   // enable fell, settle verdict
  } ctrlStrobe_t;

endpackage

// File: rtl/bist_chk_ctrl.sv
module bist_chk_ctrl
  import bist_chk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bistEn,
  input  logic        pllLock,
  output ctrlStrobe_t strb
);

  bistState_e state, nextState;
  logic       enPrev;
  logic       enRise;

  assign enRise = bistEn & ~enPrev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enPrev <= 1'b0;
      state  <= ST_IDLE;
    end else begin
      enPrev <= bistEn;
      state  <= nextState;
    end
  end

  always_comb begin
    nextState     = state;
    strb          = '0;
    strb.clearRes = enRise;
    case (state)
      ST_IDLE, ST_HOLD: begin
        if (enRise) nextState = ST_ARMED;
      end
      ST_ARMED: begin
        if (!bistEn) begin
          strb.endTest = 1'b1;
          nextState    = ST_HOLD;
        end else if (pllLock) begin
          strb.startChk = 1'b1;
          nextState     = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (!bistEn) begin
          strb.endTest = 1'b1;
          nextState    = ST_HOLD;
        end else if (!pllLock) begin
          strb.lockDrop = 1'b1;
          nextState     = ST_ARMED;
        end else begin
          strb.checkAct = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  // R7
  end_to_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.endTest |=> (state == ST_HOLD));

  // R5
  drop_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.lockDrop |=> (state == ST_ARMED));

  // R2
  no_check_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_CHECK) |-> !strb.checkAct);

  // R8
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strb));

endmodule

// File: rtl/bist_chk_datapath.sv
module bist_chk_datapath
  import bist_chk_pkg::*;
#(
  parameter int PAY_W = 35,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrlStrobe_t      strb,
  input  logic             pllLock,
  input  logic             payloadValid,
  input  logic [PAY_W-1:0] payload,
  output logic             passOut,
  output logic [CNT_W-1:0] errCnt,
  output logic             lockStatus
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic payErr;
  logic failSticky;
  logic passQ;
  logic [CNT_W-1:0] cntQ;
  logic lockQ;

  assign payErr = strb.checkAct & payloadValid & (|payload);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      failSticky <= 1'b0;
      passQ      <= 1'b0;
      cntQ       <= '0;
      lockQ      <= 1'b0;
    end else begin
      lockQ <= pllLock;

      if (strb.clearRes)   failSticky <= 1'b0;
      else if (payErr)     failSticky <= 1'b1;

      if (strb.clearRes)     passQ <= 1'b0;
      else if (strb.endTest) passQ <= ~failSticky;
      else if (payErr)       passQ <= 1'b0;
      else if (strb.startChk | strb.checkAct | strb.lockDrop) passQ <= 1'b1;

      if (strb.clearRes) cntQ <= '0;
      else if (strb.lockDrop && cntQ != CNT_MAX) cntQ <= cntQ + 1'b1;
    end
  end

  assign passOut    = passQ;
  assign errCnt     = cntQ;
  assign lockStatus = lockQ;

  // R3
  strobe_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    payErr |=> !passOut);

  // R1
  clear_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clearRes |=> (!passOut && errCnt == '0));

  // R6
  cnt_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (errCnt == CNT_MAX && !strb.clearRes) |=> (errCnt == CNT_MAX));

  // R5
  cnt_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.clearRes |=> (errCnt >= $past(errCnt)));

  // R9
  lock_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pllLock) |=> lockStatus);

endmodule

// File: rtl/bist_link_checker.sv
module bist_link_checker
  import bist_chk_pkg::*;
#(
  parameter int PAY_W = 35,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bistEn,
  input  logic             pllLock,
  input  logic             payloadValid,
  input  logic [PAY_W-1:0] payload,
  output logic             passOut,
  output logic [CNT_W-1:0] errCnt,
  output logic             lockStatus
);

  ctrlStrobe_t strb;

  bist_chk_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .bistEn  (bistEn),
    .pllLock (pllLock),
    .strb    (strb)
  );

  bist_chk_datapath #(
    .PAY_W (PAY_W),
    .CNT_W (CNT_W)
  ) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .strb         (strb),
    .pllLock      (pllLock),
    .payloadValid (payloadValid),
    .payload      (payload),
    .passOut      (passOut),
    .errCnt       (errCnt),
    .lockStatus   (lockStatus)
  );

endmodule

// File: tb/bist_link_checker_bench.sv
module bist_link_checker_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bistEn, pllLock, payloadValid;
  logic [34:0] payload;
  logic        passOut, lockStatus;
  logic [7:0]  errCnt;

  localparam logic [34:0] ONES = {35{1'b1}};
  localparam logic [34:0] TOPB = 35'h1 << 34;

  always #5 clk = ~clk;

  bist_link_checker u_bist_link_checker (
    .clk(clk), .rst_n(rst_n), .bistEn(bistEn), .pllLock(pllLock),
    .payloadValid(payloadValid), .payload(payload),
    .passOut(passOut), .errCnt(errCnt), .lockStatus(lockStatus)
  );

  typedef struct {
    logic       expPass;
    logic [7:0] expCnt;
    logic       expLock;
    string      req;
  } expItem_t;

  expItem_t expQ[$];
  int  checks = 0;
  int  fails  = 0;
  bit  finished = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus, queue the result expected after that edge
  task automatic step(input logic en, input logic lk, input logic v,
                      input logic [34:0] d, input logic ep,
                      input logic [7:0] ec, input string req);
    expItem_t it;
    @(negedge clk);
    bistEn = en; pllLock = lk; payloadValid = v; payload = d;
    @(posedge clk);
    #2;
    it.expPass = ep; it.expCnt = ec; it.expLock = lk; it.req = req;
    expQ.push_back(it);
  endtask

  // monitor: pop and compare
  initial begin
    forever begin : mon
      expItem_t it;
      @(posedge clk);
      #3;
      if (expQ.size() > 0) begin
        it = expQ.pop_front();
        chk(it.req, "passOut", {31'd0, passOut}, {31'd0, it.expPass});
        chk(it.req, "errCnt", {24'd0, errCnt}, {24'd0, it.expCnt});
        chk("R9", "lockStatus", {31'd0, lockStatus}, {31'd0, it.expLock});
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bistEn = 1'b0; pllLock = 1'b0; payloadValid = 1'b0; payload = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10", "passOut", {31'd0, passOut}, 32'd0);
    chk("R10", "errCnt", {24'd0, errCnt}, 32'd0);
    chk("R10", "lockStatus", {31'd0, lockStatus}, 32'd0);
    rst_n = 1'b1;

    // test 1: errors and lock losses
    step(1, 0, 0, '0,   0, 0, "R1");
    step(1, 0, 0, '0,   0, 0, "R1");
    step(1, 1, 1, ONES, 1, 0, "R2");
    step(1, 1, 1, '0,   1, 0, "R4");
    step(1, 1, 1, TOPB, 0, 0, "R3");
    step(1, 1, 0, ONES, 1, 0, "R4");
    step(1, 1, 1, ONES, 0, 0, "R3");
    step(1, 1, 1, 35'h1, 0, 0, "R3");
    step(1, 1, 1, '0,   1, 0, "R3");
    step(1, 0, 1, ONES, 1, 1, "R5");  // errored payload with lock drop: ignored
    step(1, 0, 1, ONES, 1, 1, "R5");
    step(1, 1, 1, ONES, 1, 1, "R5");
    step(1, 0, 0, '0,   1, 2, "R5");
    step(1, 1, 0, '0,   1, 2, "R5");
    step(0, 1, 0, '0,   0, 2, "R7");
    step(0, 0, 1, ONES, 0, 2, "R8");
    step(0, 1, 1, ONES, 0, 2, "R8");

    // test 2: clean run
    step(1, 1, 0, '0, 0, 0, "R1");
    step(1, 1, 1, '0, 1, 0, "R2");
    step(1, 1, 1, '0, 1, 0, "R4");
    step(0, 1, 0, '0, 1, 0, "R7");
    step(0, 0, 0, '0, 1, 0, "R8");

    // test 3: error just before enable falls
    step(1, 1, 0, '0,   0, 0, "R1");
    step(1, 1, 0, '0,   1, 0, "R2");
    step(1, 1, 1, 35'h4, 0, 0, "R3");
    step(0, 1, 0, '0,   0, 0, "R7");

    // test 4: errored payload in the cycle enable is low
    step(1, 1, 0, '0,   0, 0, "R1");
    step(1, 1, 0, '0,   1, 0, "R2");
    step(0, 1, 1, ONES, 1, 0, "R7");

    // test 5: end before lock ever seen
    step(1, 0, 0, '0, 0, 0, "R1");
    step(0, 0, 0, '0, 1, 0, "R7");

    // test 6: saturation of the lock-loss counter
    step(1, 0, 0, '0, 0, 0, "R1");
    for (int k = 0; k < 260; k++) begin
      step(1, 1, 0, '0, 1, (k > 255) ? 8'd255 : 8'(k), "R6");
      step(1, 0, 0, '0, 1, (k + 1 > 255) ? 8'd255 : 8'(k + 1), "R6");
    end
    step(0, 0, 0, '0, 1, 255, "R7");
    step(0, 1, 1, ONES, 1, 255, "R8");

    @(posedge clk); #4;
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R10", "passOut", {31'd0, passOut}, 32'd0);
    chk("R10", "errCnt", {24'd0, errCnt}, 32'd0);
    chk("R10", "lockStatus", {31'd0, lockStatus}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule